// File: doc/BRIEF.md
# CPU Address Space Decoder with Switchable RAM Banks

This block sits on the 16-bit address bus of a small 8-bit processor. For each bus cycle it works out which target owns the address. The possible targets are the peripheral register window, the page-zero RAM, the upper RAM, a configuration byte or the program flash. It raises the one matching select line. When the address belongs to no mapped or reserved region, it raises an illegal-access flag, which a reset controller can use to restart the system.

The block holds the configuration byte itself. Two bits of that byte each switch off one 128-byte bank at the top of the upper RAM, so firmware can run as if the part had less memory. A switched-off bank behaves like a quiet hole: no RAM select is raised, reads return zero and the access is not flagged. The block also supplies read data for its own locations: the configuration byte, the reserved hole and the switched-off banks.

All outputs are combinational from the current bus cycle and are qualified by the address strobe. Writes to the configuration byte take effect at the rising clock edge of the write cycle.

Top module: `addr_space_decoder`

## Requirements
- R1: When bus_valid is 1 and the address is in $0000-$003F, sel_periph is 1 and every other select and illegal_access are 0.
- R2: When bus_valid is 1 and the address is in $0080-$00FF, sel_ram_zp is 1.
- R3: When bus_valid is 1, sel_ram_up is 1 for $0180-$01FF. It is also 1 for $0200-$027F while config bit 0 is 0, and for $0280-$02FF while config bit 1 is 0.
- R4: An access to a bank whose config bit is 1 gives sel_ram_up 0, local_rd_en 1, local_rdata $00 and illegal_access 0.
- R5: When bus_valid is 1 and the address is in $8000-$FFFF, sel_flash is 1.
- R6: Address $0FFF raises sel_cfg and local_rd_en, and local_rdata shows the config bits in bits [1:0], with bits [7:2] reading 0. A write there with bus_valid 1 loads wdata[1:0] at the clock edge, and wdata[7:2] is ignored.
- R7: After reset both config bits are 0, so both banks are enabled.
- R8: When bus_valid is 1, illegal_access is 1 exactly for $0040-$007F, $0300-$0FFE and $1000-$7FFF.
- R9: The range $0100-$017F raises no select and no illegal flag, reads as $00 with local_rd_en 1, and writes there leave the config bits unchanged.
- R10: While bus_valid is 0, all selects, local_rd_en, illegal_access and local_rdata are 0, and a write to $0FFF has no effect.
- R11: At most one of sel_periph, sel_ram_zp, sel_ram_up, sel_cfg and sel_flash is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Address strobe qualifying the current cycle |
| bus_addr | input | 16 | CPU address |
| bus_we | input | 1 | 1 = write cycle |
| bus_wdata | input | 8 | CPU write data |
| sel_periph | output | 1 | Peripheral register window select |
| sel_ram_zp | output | 1 | Page-zero RAM select |
| sel_ram_up | output | 1 | Upper RAM select |
| sel_cfg | output | 1 | Configuration byte select |
| sel_flash | output | 1 | Program flash select |
| local_rd_en | output | 1 | This block drives the read data |
| local_rdata | output | 8 | Read data from this block |
| illegal_access | output | 1 | Access to an unmapped address |

## Verification
The bench goes after the range edges on both sides of every boundary, under all four config settings. A comparator that is off by one would raise the wrong select, or flag an address next to a region as illegal, at just those edges. It writes to the reserved hole and to $0FFF with the strobe low, and then reads the config byte back. A decoder that does not fully qualify its write enable would show changed bits in that read. Garbage in the upper write-data bits and random traffic that now and then rewrites the config byte check that a bank switched off in mid-run turns quiet at once. It must neither keep its select nor be flagged as illegal.

// File: rtl/amd_pkg.sv
package amd_pkg;
  localparam int AW         = 16;
  localparam int DW         = 8;
  localparam int NUM_BANKS  = 2;
  localparam int BANK_SPAN  = 128;
  localparam int BANK_SHIFT = $clog2(BANK_SPAN);
  localparam int BIX_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  localparam logic [AW-1:0] PERIPH_HI = 16'h003F;
  localparam logic [AW-1:0] ZP_LO     = 16'h0080;
  localparam logic [AW-1:0] ZP_HI     = 16'h00FF;
  localparam logic [AW-1:0] GAP_LO    = 16'h0100;
  localparam logic [AW-1:0] GAP_HI    = 16'h017F;
  localparam logic [AW-1:0] UP_LO     = 16'h0180;
  localparam logic [AW-1:0] UP_HI     = 16'h01FF;
  localparam logic [AW-1:0] BANK_LO   = 16'h0200;
  localparam logic [AW-1:0] BANK_HI   = AW'(int'(BANK_LO) + NUM_BANKS * BANK_SPAN - 1);
  localparam logic [AW-1:0] CFG_ADDR  = 16'h0FFF;
  localparam logic [AW-1:0] FLASH_LO  = 16'h8000;

  typedef enum logic [2:0] {
    RG_PERIPH, RG_ZP, RG_GAP, RG_UP, RG_BANK, RG_CFG, RG_FLASH, RG_ILLEGAL
  } region_e;

  function automatic logic in_span(input logic [AW-1:0] a,
                                   input logic [AW-1:0] lo,
                                   input logic [AW-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic region_e classify(input logic [AW-1:0] a);
    if (a >= FLASH_LO)                return RG_FLASH;
    if (a == CFG_ADDR)                return RG_CFG;
    if (a <= PERIPH_HI)               return RG_PERIPH;
    if (in_span(a, ZP_LO, ZP_HI))     return RG_ZP;
    if (in_span(a, GAP_LO, GAP_HI))   return RG_GAP;
    if (in_span(a, UP_LO, UP_HI))     return RG_UP;
    if (in_span(a, BANK_LO, BANK_HI)) return RG_BANK;
    return RG_ILLEGAL;
  endfunction

  function automatic logic [BIX_W-1:0] bank_index(input logic [AW-1:0] a);
    logic [AW-1:0] off;
    off = a - BANK_LO;
    return BIX_W'(off >> BANK_SHIFT);
  endfunction
endpackage

// File: rtl/amd_classify.sv
module amd_classify
  import amd_pkg::*;
(
  input  logic [AW-1:0]    addr,
  output region_e          region,
  output logic [BIX_W-1:0] bank_idx
);
  always_comb begin
    region   = classify(addr);
    bank_idx = bank_index(addr);
  end
endmodule

// File: rtl/amd_cfg_reg.sv
module amd_cfg_reg
  import amd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [DW-1:0]        wdata,
  output logic [NUM_BANKS-1:0] bank_off,
  output logic [DW-1:0]        rd_value
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bank_off[b] <= 1'b0;
      else if (wr_en) bank_off[b] <= wdata[b];
    end
  end

  assign rd_value = DW'(bank_off);

  // R6 / R9 / R10: the bank bits move only on a qualified config write
  assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(bank_off));
endmodule

// File: rtl/amd_select.sv
module amd_select
  import amd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 valid,
  input  region_e              region,
  input  logic [BIX_W-1:0]     bank_idx,
  input  logic [NUM_BANKS-1:0] bank_off,
  input  logic [DW-1:0]        cfg_value,
  output logic                 sel_periph,
  output logic                 sel_ram_zp,
  output logic                 sel_ram_up,
  output logic                 sel_cfg,
  output logic                 sel_flash,
  output logic                 local_rd_en,
  output logic [DW-1:0]        local_rdata,
  output logic                 illegal_access
);
  logic bank_is_off;
  assign bank_is_off = bank_off[bank_idx];

  always_comb begin
    sel_periph     = 1'b0;
    sel_ram_zp     = 1'b0;
    sel_ram_up     = 1'b0;
    sel_cfg        = 1'b0;
    sel_flash      = 1'b0;
    local_rd_en    = 1'b0;
    local_rdata    = '0;
    illegal_access = 1'b0;
    if (valid) begin
      unique case (region)
        RG_PERIPH:  sel_periph = 1'b1;
        RG_ZP:      sel_ram_zp = 1'b1;
        RG_GAP:     local_rd_en = 1'b1;
        RG_UP:      sel_ram_up = 1'b1;
        RG_BANK: begin
          if (bank_is_off) local_rd_en = 1'b1;
          else             sel_ram_up  = 1'b1;
        end
        RG_CFG: begin
          sel_cfg     = 1'b1;
          local_rd_en = 1'b1;
          local_rdata = cfg_value;
        end
        RG_FLASH:   sel_flash = 1'b1;
        default:    illegal_access = 1'b1;
      endcase
    end
  end

  // R11: never two targets at once
  assert_one_target_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_periph, sel_ram_zp, sel_ram_up, sel_cfg, sel_flash}));

  // R10: no flag without the strobe
  assert_flag_needs_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_access |-> valid);
endmodule

// File: rtl/addr_space_decoder.sv
module addr_space_decoder
  import amd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic [15:0]   bus_addr,
  input  logic          bus_we,
  input  logic [7:0]    bus_wdata,
  output logic          sel_periph,
  output logic          sel_ram_zp,
  output logic          sel_ram_up,
  output logic          sel_cfg,
  output logic          sel_flash,
  output logic          local_rd_en,
  output logic [7:0]    local_rdata,
  output logic          illegal_access
);
  region_e              region;
  logic [BIX_W-1:0]     bank_idx;
  logic [NUM_BANKS-1:0] bank_off;
  logic [DW-1:0]        cfg_value;
  logic                 cfg_wr;

  amd_classify u_classify (
    .addr     (bus_addr),
    .region   (region),
    .bank_idx (bank_idx)
  );

  assign cfg_wr = bus_valid && bus_we && (region == RG_CFG);

  amd_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr),
    .wdata    (bus_wdata),
    .bank_off (bank_off),
    .rd_value (cfg_value)
  );

  amd_select u_select (
    .clk            (clk),
    .rst_n          (rst_n),
    .valid          (bus_valid),
    .region         (region),
    .bank_idx       (bank_idx),
    .bank_off       (bank_off),
    .cfg_value      (cfg_value),
    .sel_periph     (sel_periph),
    .sel_ram_zp     (sel_ram_zp),
    .sel_ram_up     (sel_ram_up),
    .sel_cfg        (sel_cfg),
    .sel_flash      (sel_flash),
    .local_rd_en    (local_rd_en),
    .local_rdata    (local_rdata),
    .illegal_access (illegal_access)
  );

  // R4: a switched-off bank is quiet, not flagged
  assert_off_bank_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && region == RG_BANK && bank_off[bank_idx])
      |-> (!sel_ram_up && !illegal_access && local_rd_en && local_rdata == '0));
endmodule

// File: tb/addr_space_decoder_test.sv
module addr_space_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic        sel_periph, sel_ram_zp, sel_ram_up, sel_cfg, sel_flash;
  logic        local_rd_en, illegal_access;
  logic [7:0]  local_rdata;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;
  int model_cfg = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_space_decoder uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .sel_periph(sel_periph),
    .sel_ram_zp(sel_ram_zp), .sel_ram_up(sel_ram_up), .sel_cfg(sel_cfg),
    .sel_flash(sel_flash), .local_rd_en(local_rd_en), .local_rdata(local_rdata),
    .illegal_access(illegal_access)
  );

  // Expected output word:
  // {periph, zp, up, cfg, flash, local_rd_en, illegal, rdata[7:0]}
  function automatic logic [14:0] predict(input int a, input bit v, input int cfg);
    bit p = 0, z = 0, u = 0, c = 0, f = 0, l = 0, il = 0;
    int rd = 0;
    if (v) begin
      if (a < 'h40) p = 1;
      else if (a < 'h80) il = 1;
      else if (a < 'h100) z = 1;
      else if (a < 'h180) l = 1;
      else if (a < 'h200) u = 1;
      else if (a < 'h280) begin if (cfg[0]) l = 1; else u = 1; end
      else if (a < 'h300) begin if (cfg[1]) l = 1; else u = 1; end
      else if (a == 'hFFF) begin c = 1; l = 1; rd = cfg; end
      else if (a < 'h8000) il = 1;
      else f = 1;
    end
    return {p, z, u, c, f, l, il, 8'(rd)};
  endfunction

  function automatic string tag_of(input int a, input bit v);
    if (!v) return "R10";
    if (a < 'h40) return "R1";
    if (a < 'h80) return "R8";
    if (a < 'h100) return "R2";
    if (a < 'h180) return "R9";
    if (a < 'h200) return "R3";
    if (a < 'h300) return "R3/R4";
    if (a == 'hFFF) return "R6";
    if (a < 'h8000) return "R8";
    return "R5";
  endfunction

  task automatic apply(input int a, input bit v, input bit we, input int wd, input string tag);
    logic [14:0] got, exp;
    @(negedge clk);
    bus_addr = 16'(a); bus_valid = v; bus_we = we; bus_wdata = 8'(wd);
    #1;
    exp = predict(a, v, model_cfg);
    got = {sel_periph, sel_ram_zp, sel_ram_up, sel_cfg, sel_flash,
           local_rd_en, illegal_access, local_rdata};
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s addr=%h valid=%0d we=%0d got=%b expected=%b",
               (tag == "") ? tag_of(a, v) : tag, a, v, we, got, exp);
    end
    @(posedge clk);
    if (v && we && a == 'hFFF) model_cfg = wd & 3;
  endtask

  initial begin
    int bnd [24] = '{'h0000, 'h003F, 'h0040, 'h007F, 'h0080, 'h00FF, 'h0100, 'h017F,
                     'h0180, 'h01FF, 'h0200, 'h027F, 'h0280, 'h02FF, 'h0300, 'h0FFE,
                     'h0FFF, 'h1000, 'h7FFF, 'h8000, 'hFFFF, 'h0241, 'h02C3, 'h4000};
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    apply('hFFF, 1, 0, 0, "R7");        // both bits clear after reset
    apply('h0200, 1, 0, 0, "R7");
    apply('h0280, 1, 0, 0, "R7");
    for (int c = 0; c < 4; c++) begin
      apply('hFFF, 1, 1, 'hA8 | c, "R6"); // upper data bits are junk
      apply('hFFF, 1, 0, 0, "R6");
      for (int i = 0; i < 24; i++) begin
        apply(bnd[i], 1, 0, 0, "");
        apply(bnd[i], 1, 1, 'h5A, "");
      end
    end
    apply('hFFF, 1, 1, 'h02, "R6");
    apply('h0150, 1, 1, 'hFF, "R9");    // write into the hole
    apply('hFFF, 1, 0, 0, "R9");
    apply('hFFF, 0, 1, 'h01, "R10");    // strobe low: no load
    apply('hFFF, 1, 0, 0, "R10");
    apply('h0040, 0, 0, 0, "R10");
    apply('h0280, 1, 0, 0, "R4");
    for (int n = 0; n < 4000; n++) begin
      int a;
      bit v, we;
      a  = (n % 3 == 0) ? int'($urandom_range(0, 'h3FF)) : int'($urandom_range(0, 'hFFFF));
      if (n % 97 == 0) a = 'hFFF;
      v  = ($urandom_range(0, 7) != 0);
      we = ($urandom_range(0, 3) == 0) || (a == 'hFFF);
      apply(a, v, we, int'($urandom_range(0, 255)), "");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired got=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule